// File: doc/BRIEF.md
# PIO Byte-Count Data Mover

This block carries out one data-request burst of packet-command programmed I/O. The device side is a 16-bit data port with a request/acknowledge handshake. The host side is a byte-addressed buffer. When a burst starts, the block captures the device byte count from two 8-bit count registers, the buffer base address and the host residual byte count. It then moves the smaller of the two counts.

Whole 16-bit words move first. If the transfer count is odd, the final byte is handled as a half-used word. On input it reads and drops any device bytes beyond what the buffer can take.

After the last data port access the block waits a fixed settle time, then pulses `done`. The updated residual and buffer pointer are on its outputs. The block that issues the command and decodes the interrupt reason pulses `startStb` once per data-request phase.

Top module: `pio_mover`

## Requirements
- R1: A `startStb` pulse while `busy` is low begins a burst and samples `dirIn` (1 = device to buffer, 0 = buffer to device), `residIn`, `baseAddr` and the device byte count D = `cylHi`*256 + `cylLo`. A `startStb` pulse while `busy` is high has no effect. While idle, no data port or buffer strobe is active.
- R2: The transfer count X is min(`residIn`, D). After the burst, `resid` equals `residIn` − X.
- R3: On input, whole words are read before any odd byte. The low byte of each word is written to the lower buffer address and the high byte to the next address.
- R4: On input with odd X, one extra word is read. Only its low byte is written to the buffer, so the byte at `baseAddr`+X is left untouched.
- R5: On output, each device word is formed as {byte at address 2j+1, byte at address 2j} relative to `baseAddr`. For odd X the final word is {8'h00, last byte}.
- R6: On input, the total number of device word reads is ceil(D/2). Words beyond those that carry buffer data are discarded, with no buffer write.
- R7: On output, exactly ceil(X/2) device word writes occur, and no buffer reads occur on input.
- R8: Buffer accesses use consecutive addresses starting at `baseAddr`. After the burst, `bufAddr` equals `baseAddr` + X.
- R9: `done` is a one-cycle pulse. At least SETTLE_NS worth of clock cycles (80 cycles at defaults) separate the last data port transfer from `done`. `busy` drops in the cycle after `done`.
- R10: With D = 0, `done` is high in the second cycle after the start edge, and there is no data port or buffer access at all.
- R11: Data port handshake: `devRd` or `devWr` stays high until the cycle in which `devAck` is high. `devWrData` is stable while `devWr` waits. Each acknowledged cycle moves one word, and `devRd` and `devWr` are never both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startStb | input | 1 | Begin a burst (ignored while busy) |
| dirIn | input | 1 | 1 = device to buffer, 0 = buffer to device |
| cylLo | input | 8 | Device byte count, low byte |
| cylHi | input | 8 | Device byte count, high byte |
| residIn | input | RES_W | Host residual byte count at start |
| baseAddr | input | ADDR_W | Buffer address of the first byte |
| busy | output | 1 | Burst in progress |
| done | output | 1 | One-cycle end-of-burst pulse |
| resid | output | RES_W | Updated residual byte count |
| bufAddr | output | ADDR_W | Buffer pointer and access address |
| devRd | output | 1 | Device data read request |
| devWr | output | 1 | Device data write request |
| devWrData | output | 16 | Word written to the device |
| devRdData | input | 16 | Word read from the device, valid with devAck |
| devAck | input | 1 | Device accepts or supplies a word |
| bufRe | output | 1 | Buffer read strobe, data one cycle later |
| bufWe | output | 1 | Buffer byte write strobe |
| bufWrData | output | 8 | Byte written to the buffer |
| bufRdData | input | 8 | Byte read from the buffer |

## Verification
A wrong word or drain counter shows up as a device read or write count that differs from ceil(D/2) or ceil(X/2). It also corrupts the sentinel byte just past the buffer end, which is visible as soon as the burst's `done` arrives. A byte-lane or odd-byte slip appears in the very first word compared, as a swapped or non-zero high byte. A residual or pointer error shows on `resid` and `bufAddr` from the cycle after start or at `done`. A short settle count shows as a `done` arriving fewer than 80 cycles after the last acknowledge.

// File: rtl/pio_mover_pkg.sv
package pio_mover_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // capture start inputs, compute counts
    logic capDev;   // capture device word
    logic capLo;    // capture buffer byte as low byte, clear high byte
    logic capHi;    // capture buffer byte as high byte
    logic advAddr;  // buffer pointer + 1
    logic decWord;  // one whole word finished
    logic clrOdd;   // odd byte finished
    logic decDrain; // one surplus word dropped
    logic selHi;    // buffer write takes high byte
  } moverCmd_t;

  // status from datapath to control
  typedef struct packed {
    logic dirIn;
    logic zeroCnt;
    logic wordsPend;
    logic oddPend;
    logic drainPend;
  } moverStat_t;

  typedef enum logic [3:0] {
    ST_IDLE, ST_PICK, ST_IN_RD, ST_IN_WLO, ST_IN_WHI,
    ST_OUT_RLO, ST_OUT_CLO, ST_OUT_RHI, ST_OUT_CHI, ST_OUT_WR,
    ST_DRAIN, ST_SETTLE, ST_DONE
  } moverState_t;

endpackage

// File: rtl/pio_mover_dp.sv
module pio_mover_dp
  import pio_mover_pkg::*;
#(
  parameter int RES_W  = 20,  // must be at least 16
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  moverCmd_t         cmd,
  input  logic              startDirIn,
  input  logic [7:0]        cylLo,
  input  logic [7:0]        cylHi,
  input  logic [RES_W-1:0]  residIn,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic [15:0]       devRdData,
  input  logic [7:0]        bufRdData,
  output moverStat_t        stat,
  output logic [RES_W-1:0]  resid,
  output logic [ADDR_W-1:0] bufAddr,
  output logic [15:0]       devWrData,
  output logic [7:0]        bufWrData
);

  logic              dirReg;
  logic [15:0]       devCnt;
  logic [14:0]       wordsLeft;
  logic              oddLeft;
  logic [15:0]       drainLeft;
  logic [ADDR_W-1:0] addrReg;
  logic [RES_W-1:0]  residReg;
  logic [15:0]       wordReg;

  // start-time arithmetic
  logic [15:0] devCntNext;
  logic        residShort;
  logic [15:0] xferNext;
  logic [15:0] ceilDev;
  logic [15:0] ceilXfer;
  logic [15:0] drainNext;

  always_comb begin
    devCntNext = {cylHi, cylLo};
    residShort = residIn < RES_W'(devCntNext);
    xferNext   = residShort ? residIn[15:0] : devCntNext;
    ceilDev    = {1'b0, devCntNext[15:1]} + {15'd0, devCntNext[0]};
    ceilXfer   = {1'b0, xferNext[15:1]} + {15'd0, xferNext[0]};
    // every device word not carrying buffer data is dropped on input
    drainNext  = startDirIn ? (ceilDev - ceilXfer) : 16'd0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dirReg    <= 1'b0;
      devCnt    <= '0;
      wordsLeft <= '0;
      oddLeft   <= 1'b0;
      drainLeft <= '0;
      addrReg   <= '0;
      residReg  <= '0;
      wordReg   <= '0;
    end else begin
      if (cmd.load) begin
        dirReg    <= startDirIn;
        devCnt    <= devCntNext;
        wordsLeft <= xferNext[15:1];
        oddLeft   <= xferNext[0];
        drainLeft <= drainNext;
        addrReg   <= baseAddr;
        residReg  <= residIn - RES_W'(xferNext);
      end
      if (cmd.capDev) wordReg <= devRdData;
      if (cmd.capLo)  wordReg <= {8'h00, bufRdData};
      if (cmd.capHi)  wordReg[15:8] <= bufRdData;
      if (cmd.advAddr)  addrReg   <= addrReg + ADDR_W'(1);
      if (cmd.decWord)  wordsLeft <= wordsLeft - 15'd1;
      if (cmd.clrOdd)   oddLeft   <= 1'b0;
      if (cmd.decDrain) drainLeft <= drainLeft - 16'd1;
    end
  end

  always_comb begin
    stat.dirIn     = dirReg;
    stat.zeroCnt   = (devCnt == 16'd0);
    stat.wordsPend = (wordsLeft != 15'd0);
    stat.oddPend   = oddLeft;
    stat.drainPend = (drainLeft != 16'd0);
  end

  assign resid     = residReg;
  assign bufAddr   = addrReg;
  assign devWrData = wordReg;
  assign bufWrData = cmd.selHi ? wordReg[15:8] : wordReg[7:0];

endmodule

// File: rtl/pio_mover_ctl.sv
module pio_mover_ctl
  import pio_mover_pkg::*;
#(
  parameter int SETTLE_CYC = 80
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startStb,
  input  logic       devAck,
  input  moverStat_t stat,
  output moverCmd_t  cmd,
  output logic       devRd,
  output logic       devWr,
  output logic       bufRe,
  output logic       bufWe,
  output logic       busy,
  output logic       done
);

  localparam int SET_W = $clog2(SETTLE_CYC + 1);
  localparam logic [SET_W-1:0] SET_LAST = SET_W'(SETTLE_CYC - 1);

  moverState_t state, nextState;
  logic [SET_W-1:0] settleCnt;

  always_comb begin
    nextState = state;
    cmd   = '0;
    devRd = 1'b0;
    devWr = 1'b0;
    bufRe = 1'b0;
    bufWe = 1'b0;
    done  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (startStb) begin
          cmd.load  = 1'b1;
          nextState = ST_PICK;
        end
      end
      ST_PICK: begin
        if (stat.zeroCnt)                      nextState = ST_DONE;
        else if (stat.wordsPend || stat.oddPend)
          nextState = stat.dirIn ? ST_IN_RD : ST_OUT_RLO;
        else if (stat.drainPend)               nextState = ST_DRAIN;
        else                                   nextState = ST_SETTLE;
      end
      ST_IN_RD: begin
        devRd = 1'b1;
        if (devAck) begin
          cmd.capDev = 1'b1;
          nextState  = ST_IN_WLO;
        end
      end
      ST_IN_WLO: begin
        bufWe       = 1'b1;
        cmd.advAddr = 1'b1;
        if (stat.wordsPend) nextState = ST_IN_WHI;
        else begin
          cmd.clrOdd = 1'b1;
          nextState  = ST_PICK;
        end
      end
      ST_IN_WHI: begin
        bufWe       = 1'b1;
        cmd.selHi   = 1'b1;
        cmd.advAddr = 1'b1;
        cmd.decWord = 1'b1;
        nextState   = ST_PICK;
      end
      ST_OUT_RLO: begin
        bufRe     = 1'b1;
        nextState = ST_OUT_CLO;
      end
      ST_OUT_CLO: begin
        cmd.capLo   = 1'b1;
        cmd.advAddr = 1'b1;
        nextState   = stat.wordsPend ? ST_OUT_RHI : ST_OUT_WR;
      end
      ST_OUT_RHI: begin
        bufRe     = 1'b1;
        nextState = ST_OUT_CHI;
      end
      ST_OUT_CHI: begin
        cmd.capHi   = 1'b1;
        cmd.advAddr = 1'b1;
        nextState   = ST_OUT_WR;
      end
      ST_OUT_WR: begin
        devWr = 1'b1;
        if (devAck) begin
          if (stat.wordsPend) cmd.decWord = 1'b1;
          else                cmd.clrOdd  = 1'b1;
          nextState = ST_PICK;
        end
      end
      ST_DRAIN: begin
        devRd = 1'b1;
        if (devAck) begin
          cmd.decDrain = 1'b1;
          nextState    = ST_PICK;
        end
      end
      ST_SETTLE: begin
        if (settleCnt == SET_LAST) nextState = ST_DONE;
      end
      ST_DONE: begin
        done      = 1'b1;
        nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      settleCnt <= '0;
    end else begin
      state <= nextState;
      if (state == ST_SETTLE) settleCnt <= settleCnt + SET_W'(1);
      else                    settleCnt <= '0;
    end
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/pio_mover.sv
module pio_mover
  import pio_mover_pkg::*;
#(
  parameter int RES_W         = 20,
  parameter int ADDR_W        = 12,
  parameter int CLK_PERIOD_NS = 5,
  parameter int SETTLE_NS     = 400
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startStb,
  input  logic              dirIn,
  input  logic [7:0]        cylLo,
  input  logic [7:0]        cylHi,
  input  logic [RES_W-1:0]  residIn,
  input  logic [ADDR_W-1:0] baseAddr,
  output logic              busy,
  output logic              done,
  output logic [RES_W-1:0]  resid,
  output logic [ADDR_W-1:0] bufAddr,
  output logic              devRd,
  output logic              devWr,
  output logic [15:0]       devWrData,
  input  logic [15:0]       devRdData,
  input  logic              devAck,
  output logic              bufRe,
  output logic              bufWe,
  output logic [7:0]        bufWrData,
  input  logic [7:0]        bufRdData
);

  localparam int SETTLE_RAW = (SETTLE_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
  localparam int SETTLE_CYC = (SETTLE_RAW < 1) ? 1 : SETTLE_RAW;

  moverCmd_t  cmd;
  moverStat_t stat;

  pio_mover_ctl #(.SETTLE_CYC(SETTLE_CYC)) u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .startStb (startStb),
    .devAck   (devAck),
    .stat     (stat),
    .cmd      (cmd),
    .devRd    (devRd),
    .devWr    (devWr),
    .bufRe    (bufRe),
    .bufWe    (bufWe),
    .busy     (busy),
    .done     (done)
  );

  pio_mover_dp #(.RES_W(RES_W), .ADDR_W(ADDR_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .cmd        (cmd),
    .startDirIn (dirIn),
    .cylLo      (cylLo),
    .cylHi      (cylHi),
    .residIn    (residIn),
    .baseAddr   (baseAddr),
    .devRdData  (devRdData),
    .bufRdData  (bufRdData),
    .stat       (stat),
    .resid      (resid),
    .bufAddr    (bufAddr),
    .devWrData  (devWrData),
    .bufWrData  (bufWrData)
  );

endmodule

// File: rtl/pio_mover_chk.sv
module pio_mover_chk (
  input logic        clk,
  input logic        rstN,
  input logic        busy,
  input logic        done,
  input logic        devRd,
  input logic        devWr,
  input logic [15:0] devWrData,
  input logic        devAck,
  input logic        bufRe,
  input logic        bufWe
);

  // R11: read request held until acknowledged
  a_r11_rd_hold: assert property (@(posedge clk) disable iff (!rstN)
    (devRd && !devAck) |=> devRd);

  // R11: write request and its data held until acknowledged
  a_r11_wr_hold: assert property (@(posedge clk) disable iff (!rstN)
    (devWr && !devAck) |=> (devWr && $stable(devWrData)));

  // R11: never read and write the device at once
  a_r11_rd_wr_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(devRd && devWr));

  // R1: quiet while idle
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !(devRd || devWr || bufRe || bufWe));

  // R9: done is a single pulse and ends the burst
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && !busy));

  // R9: done only during a burst
  a_r9_done_busy: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy);

endmodule

bind pio_mover pio_mover_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busy      (busy),
  .done      (done),
  .devRd     (devRd),
  .devWr     (devWr),
  .devWrData (devWrData),
  .devAck    (devAck),
  .bufRe     (bufRe),
  .bufWe     (bufWe)
);

// File: tb/test_pio_mover.sv
`timescale 1ns/1ps
module test_pio_mover;

  localparam int RES_W  = 20;
  localparam int ADDR_W = 12;
  localparam int SETTLE = 80;   // 400 ns at 5 ns

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              startStb = 1'b0;
  logic              dirIn = 1'b0;
  logic [7:0]        cylLo = '0, cylHi = '0;
  logic [RES_W-1:0]  residIn = '0;
  logic [ADDR_W-1:0] baseAddr = '0;
  logic              busy, done;
  logic [RES_W-1:0]  resid;
  logic [ADDR_W-1:0] bufAddr;
  logic              devRd, devWr;
  logic [15:0]       devWrData;
  logic [15:0]       devRdData = '0;
  logic              devAck = 1'b0;
  logic              bufRe, bufWe;
  logic [7:0]        bufWrData;
  logic [7:0]        bufRdData = '0;

  always #2.5 clk = ~clk;

  pio_mover #(.RES_W(RES_W), .ADDR_W(ADDR_W)) i_pio_mover (.*);

  int testCnt = 0, failCnt = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // bench models
  logic [7:0]  mem [0:511];
  logic [15:0] wrLog [0:511];
  int rdCount, wrCount, bufWrCount, bufRdCount, orderBad;
  int lastXferCyc, curBase, curD;
  int ackWait = 0, ackPat = 0;

  function automatic logic [15:0] devWord(int i, int d);
    return 16'(i * 32'h0305 + d * 32'h1111 + 32'h10A1);
  endfunction

  function automatic logic [7:0] pat(int i);
    return 8'(i * 13 + 7);
  endfunction

  always @(negedge clk) begin
    if (devAck) begin
      devAck  <= 1'b0;
      ackWait <= ackPat;
      ackPat  <= (ackPat + 1) % 3;
    end else if (devRd || devWr) begin
      if (ackWait == 0) begin
        devAck <= 1'b1;
        lastXferCyc = cyc + 1;
        if (devRd) begin
          devRdData <= devWord(rdCount, curD);
          rdCount = rdCount + 1;
        end else begin
          wrLog[wrCount[8:0]] = devWrData;
          wrCount = wrCount + 1;
        end
      end else ackWait <= ackWait - 1;
    end
    if (bufWe) begin
      if (int'(bufAddr) != curBase + bufWrCount) orderBad = orderBad + 1;
      mem[bufAddr[8:0]] = bufWrData;
      bufWrCount = bufWrCount + 1;
    end
    if (bufRe) begin
      if (int'(bufAddr) != curBase + bufRdCount) orderBad = orderBad + 1;
      bufRdData <= mem[bufAddr[8:0]];
      bufRdCount = bufRdCount + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic burst(input bit din, input int d, input int r, input int base,
                       input bit glitch);
    int x, cx, cd, startCyc, doneCyc, tmo, bad;
    logic [7:0] lo, hi;
    x  = (r < d) ? r : d;
    cx = (x + 1) / 2;
    cd = (d + 1) / 2;
    @(negedge clk);
    for (int i = 0; i < 512; i++) mem[i] = din ? 8'hEE : pat(i);
    rdCount = 0; wrCount = 0; bufWrCount = 0; bufRdCount = 0; orderBad = 0;
    lastXferCyc = 0; curBase = base; curD = d;
    dirIn = din; cylLo = 8'(d); cylHi = 8'(d >> 8);
    residIn = RES_W'(r); baseAddr = ADDR_W'(base);
    startStb = 1'b1;
    startCyc = cyc;
    @(negedge clk);
    startStb = 1'b0;
    if (glitch) begin
      repeat (3) @(negedge clk);
      dirIn = ~din; cylLo = 8'hFF; cylHi = 8'h01; residIn = RES_W'(999);
      baseAddr = ADDR_W'(5);
      startStb = 1'b1;
      @(negedge clk);
      startStb = 1'b0;
    end
    tmo = 0;
    while (!done && tmo < 5000) begin
      @(negedge clk);
      tmo++;
    end
    doneCyc = cyc;
    chk(done == 1'b1, "R9", "done seen", done, 1);
    chk(resid == RES_W'(r - x), "R2", "residual", resid, r - x);
    chk(bufAddr == ADDR_W'(base + x), "R8", "final pointer", bufAddr, base + x);
    chk(orderBad == 0, "R8", "address order errors", orderBad, 0);
    if (d == 0) begin
      chk(doneCyc == startCyc + 2, "R10", "zero-count done cycle", doneCyc, startCyc + 2);
      chk(rdCount + wrCount + bufWrCount + bufRdCount == 0, "R10", "accesses",
          rdCount + wrCount + bufWrCount + bufRdCount, 0);
    end
    if (din) begin
      chk(rdCount == cd, "R6", "device reads", rdCount, cd);
      chk(bufWrCount == x, "R3", "buffer writes", bufWrCount, x);
      chk(bufRdCount == 0, "R7", "buffer reads on input", bufRdCount, 0);
      bad = 0;
      for (int i = 0; i < x; i++) begin
        logic [15:0] w;
        w = devWord(i / 2, d);
        if (mem[base + i] != ((i % 2) ? w[15:8] : w[7:0])) bad++;
      end
      chk(bad == 0, "R3", "stored byte mismatches", bad, 0);
      chk(mem[base + x] == 8'hEE, (x % 2) ? "R4" : "R6", "byte past end",
          mem[base + x], 8'hEE);
    end else begin
      chk(wrCount == cx, "R7", "device writes", wrCount, cx);
      chk(bufWrCount == 0, "R7", "buffer writes on output", bufWrCount, 0);
      bad = 0;
      for (int j = 0; j < cx; j++) begin
        lo = pat(base + 2 * j);
        hi = (2 * j + 1 < x) ? pat(base + 2 * j + 1) : 8'h00;
        if (wrLog[j] != {hi, lo}) bad++;
      end
      chk(bad == 0, "R5", "written word mismatches", bad, 0);
    end
    if (rdCount + wrCount > 0)
      chk(doneCyc - lastXferCyc >= SETTLE, "R9", "settle cycles",
          doneCyc - lastXferCyc, SETTLE);
    @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0, "R9", "idle after done", {busy, done}, 0);
  endtask

  initial begin
    #(5.0 * 190000);
    failCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0, "R1", "reset busy/done", {busy, done}, 0);
    chk(!devRd && !devWr && !bufWe && !bufRe, "R1", "reset strobes",
        {devRd, devWr, bufWe, bufRe}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(resid == '0 && bufAddr == '0, "R2", "reset resid/pointer", resid, 0);
    // sweep small counts, both directions
    for (int din = 0; din < 2; din++)
      for (int d = 0; d < 10; d++)
        for (int r = 0; r < 10; r++)
          burst(din[0], d, r, (din * 37 + d * 11 + r * 3) % 128, 1'b0);
    // R1: start pulse during a burst is ignored
    burst(1'b1, 7, 5, 20, 1'b1);
    burst(1'b0, 9, 4, 30, 1'b1);
    // long bursts with surplus drain and large counts
    burst(1'b1, 300, 37, 64, 1'b0);
    burst(1'b0, 300, 37, 64, 1'b0);
    burst(1'b1, 301, 500, 100, 1'b0);
    burst(1'b0, 301, 500, 100, 1'b0);
    burst(1'b1, 257, 256, 0, 1'b0);
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule